// File: doc/BRIEF.md
# Configuration Hex Record Decoder

This block takes a text file in the Intel-HEX record format, one ASCII character per valid/ready handshake, and pulls a configuration image out of it. Each record is parsed, its per-record checksum is verified, and 32-bit byte addresses are formed from the record address plus the upper half supplied by extended linear address records. Bytes that land in one of three fixed windows are kept. These windows are a 128-byte configuration image at address 0, a two-byte image sum at 0x90300000 and a seven-byte metadata block at 0x90500000.

When the end-of-file record arrives with a good checksum, the block pulses `done`. Alongside that pulse it raises `image_ok` if three conditions hold. The 16-bit sum of the 128 configuration bytes must equal the stored sum, which is held most significant byte first. The two-byte version at the start of the metadata must read 0x0101. No parse error may have been seen. A combinational read port returns any captured byte so that a downstream programmer can fetch the image. Framing or content problems are reported through a sticky error code.

Top module: `hex_image_decoder`

## Requirements
- R1: After reset, `err_code` is 0, `done` and `image_ok` are 0, `in_ready` is 1, and every read index 0..136 returns 0xFF. Bytes that are never written keep reading 0xFF.
- R2: A type 0x00 data record writes its bytes to the consecutive addresses {upper16, addr16}+k. A byte whose address is 0x00000000..0x0000007F is readable at read index equal to that address.
- R3: A type 0x04 record with count 2 and a good checksum sets upper16 to its two data bytes, high byte first. Bytes at 0x90300000..0x90300001 read at indices 128..129, and bytes at 0x90500000..0x90500006 read at indices 130..136.
- R4: Data bytes addressed outside the three windows change no readable byte.
- R5: If the low byte of the sum of all bytes of a record (count, address, type, data, checksum) is not zero, `err_code` becomes 2.
- R6: Any character other than a hex digit inside a record, or any character other than ':', CR or LF between records, sets `err_code` to 1.
- R7: A record type other than 0x00, 0x01 or 0x04 sets `err_code` to 3.
- R8: After a valid end-of-file record, CR and LF are ignored and any other character sets `err_code` to 4.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts the last checksum digit of a good type 0x01 record.
- R10: Hex digits are accepted in either upper or lower case, and CR/LF between records are skipped without error.
- R11: The first non-zero error code is held until reset, and later errors do not replace it.
- R12: `image_ok` is 1 with `done` only when the stored sum (index 128 high, 129 low) equals the 16-bit sum of indices 0..127, the version (index 130 high, 131 low) is 0x0101, and `err_code` is 0. It drops to 0 at the edge where any later error is raised.
- R13: A type 0x04 record whose count is not 2, or a type 0x01 record whose count is not 0, sets `err_code` to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Character present on `in_char` |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted this edge (always 1) |
| rd_addr | input | 8 | Read index: 0..127 image, 128..129 sum, 130..136 metadata |
| rd_data | output | 8 | Byte at `rd_addr`, combinational |
| done | output | 1 | One-cycle pulse after a good end-of-file record |
| image_ok | output | 1 | Image consistency flag, updated with `done` |
| err_code | output | 3 | Sticky error: 0 none, 1 character, 2 checksum, 3 type, 4 after end, 5 length |

## Verification
A data byte is readable on `rd_data` right after the edge that accepts its second hex digit. `err_code` changes at the edge that accepts the offending character. `done` and `image_ok` rise at the edge that takes the final checksum digit of the end-of-file record. The bench drives each character for one edge and samples 1 ns after that edge. It checks `done` at that point and again one edge later for the fall. Read-port sweeps run only after `in_valid` has dropped, and each compares all 137 indices against patterns computed arithmetically in the bench.

// File: rtl/hexdec_pkg.sv
// Shared constants and types for the hex image decoder.
// Assumes 8-bit ASCII input and a fixed three-window section map.
package hexdec_pkg;
    localparam int CFG_BYTES  = 128;
    localparam int CK_BYTES   = 2;
    localparam int META_BYTES = 7;
    localparam int TOTAL_BYTES = CFG_BYTES + CK_BYTES + META_BYTES;
    localparam int IDX_W       = $clog2(TOTAL_BYTES + 1);

    localparam logic [31:0] CFG_BASE  = 32'h0000_0000;
    localparam logic [31:0] CK_BASE   = 32'h9030_0000;
    localparam logic [31:0] META_BASE = 32'h9050_0000;
    localparam logic [15:0] VERSION_OK = 16'h0101;

    localparam logic [7:0] REC_DATA = 8'h00;
    localparam logic [7:0] REC_EOF  = 8'h01;
    localparam logic [7:0] REC_EXT  = 8'h04;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_CHAR   = 3'd1,
        ERR_CKSUM  = 3'd2,
        ERR_TYPE   = 3'd3,
        ERR_AFTER  = 3'd4,
        ERR_LEN    = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_END  = 2'd2
    } pstate_e;
endpackage

// File: rtl/hexdec_char.sv
// Classifies one ASCII character: hex digit (either case) with its value,
// record start mark, or line ending. Purely combinational.
module hexdec_char (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib,
    output logic       is_colon,
    output logic       is_eol
);
    // Map digit characters to nibble values
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'd0;
        if (ch >= 8'h30 && ch <= 8'h39)      nib = 4'(ch - 8'h30);
        else if (ch >= 8'h41 && ch <= 8'h46) nib = 4'(ch - 8'h37);
        else if (ch >= 8'h61 && ch <= 8'h66) nib = 4'(ch - 8'h57);
        else                                 is_hex = 1'b0;
    end

    assign is_colon = (ch == 8'h3A);
    assign is_eol   = (ch == 8'h0D) || (ch == 8'h0A);
endmodule

// File: rtl/hexdec_parser.sv
// Record parser: assembles bytes from digit pairs, tracks record fields,
// checks the record checksum and emits byte writes with 32-bit addresses.
// Assumes one character per cycle when in_valid is high. Writes are issued
// as bytes arrive, before the checksum byte is seen.
module hexdec_parser
    import hexdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        ch_hex,
    input  logic [3:0]  ch_nib,
    input  logic        ch_colon,
    input  logic        ch_eol,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        eof_pulse,
    output logic        err_raise,
    output err_e        err_code
);
    pstate_e     st;
    logic        have_hi;
    logic [3:0]  nib_hi;
    logic [8:0]  pos;
    logic [7:0]  cnt;
    logic [15:0] addr16;
    logic [7:0]  rtype;
    logic [7:0]  sum8;
    logic [15:0] ext_hi;
    logic [15:0] ext_pend;
    err_e        err_q;
    err_e        new_err;

    logic        byte_done;
    logic        last;
    logic        in_data;
    logic [7:0]  cur;
    logic [7:0]  sum_next;
    logic        type_legal;

    // Field decode of the byte being completed this cycle
    always_comb begin
        cur        = {nib_hi, ch_nib};
        sum_next   = sum8 + cur;
        byte_done  = in_valid && (st == ST_REC) && ch_hex && have_hi;
        last       = (pos == 9'(cnt) + 9'd4);
        in_data    = (pos >= 9'd4) && !last;
        type_legal = (cur == REC_DATA) || (cur == REC_EOF) || (cur == REC_EXT);
    end

    // Error detection for the current character
    always_comb begin
        new_err = ERR_NONE;
        case (st)
            ST_IDLE: if (in_valid && !ch_colon && !ch_eol) new_err = ERR_CHAR;
            ST_REC: begin
                if (in_valid && !ch_hex) new_err = ERR_CHAR;
                else if (byte_done && pos == 9'd3) begin
                    if (!type_legal) new_err = ERR_TYPE;
                    else if ((cur == REC_EOF && cnt != 8'd0) ||
                             (cur == REC_EXT && cnt != 8'd2)) new_err = ERR_LEN;
                end
                else if (byte_done && pos >= 9'd4 && last && sum_next != 8'd0)
                    new_err = ERR_CKSUM;
            end
            ST_END: if (in_valid && !ch_eol) new_err = ERR_AFTER;
            default: new_err = ERR_NONE;
        endcase
    end

    // Sticky error register keeps the first code seen
    always_ff @(posedge clk) begin
        if (!rst_n)                                     err_q <= ERR_NONE;
        else if (err_q == ERR_NONE && new_err != ERR_NONE) err_q <= new_err;
    end

    // Record state machine and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            have_hi  <= 1'b0;
            nib_hi   <= 4'd0;
            pos      <= 9'd0;
            cnt      <= 8'd0;
            addr16   <= 16'd0;
            rtype    <= 8'd0;
            sum8     <= 8'd0;
            ext_hi   <= 16'd0;
            ext_pend <= 16'd0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_valid && ch_colon) begin
                        st      <= ST_REC;
                        pos     <= 9'd0;
                        have_hi <= 1'b0;
                        sum8    <= 8'd0;
                    end
                end
                ST_REC: begin
                    if (in_valid) begin
                        if (new_err != ERR_NONE) begin
                            st <= ST_IDLE;
                        end else if (!have_hi) begin
                            nib_hi  <= ch_nib;
                            have_hi <= 1'b1;
                        end else begin
                            have_hi <= 1'b0;
                            sum8    <= sum_next;
                            pos     <= pos + 9'd1;
                            case (pos)
                                9'd0: cnt           <= cur;
                                9'd1: addr16[15:8]  <= cur;
                                9'd2: addr16[7:0]   <= cur;
                                9'd3: rtype         <= cur;
                                default: begin
                                    if (rtype == REC_EXT && pos == 9'd4) ext_pend[15:8] <= cur;
                                    if (rtype == REC_EXT && pos == 9'd5) ext_pend[7:0]  <= cur;
                                end
                            endcase
                            if (pos >= 9'd4 && last) begin
                                st <= (rtype == REC_EOF) ? ST_END : ST_IDLE;
                                if (rtype == REC_EXT) ext_hi <= ext_pend;
                            end
                        end
                    end
                end
                default: st <= ST_END;
            endcase
        end
    end

    assign wr_en     = byte_done && (rtype == REC_DATA) && in_data;
    assign wr_addr   = {ext_hi, addr16} + 32'(pos - 9'd4);
    assign wr_data   = cur;
    assign eof_pulse = byte_done && (pos >= 9'd4) && last &&
                       (new_err == ERR_NONE) && (rtype == REC_EOF);
    assign err_raise = (err_q == ERR_NONE) && (new_err != ERR_NONE);
    assign err_code  = err_q;
endmodule

// File: rtl/hexdec_store.sv
// Section storage: maps 32-bit byte addresses onto the three capture
// windows, holds the captured bytes (0xFF until written), serves the read
// port and derives the image sum, stored sum and version.
module hexdec_store
    import hexdec_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [SUM_W-1:0] img_sum,
    output logic [15:0]      stored_sum,
    output logic [15:0]      version
);
    localparam int CK_IDX   = CFG_BYTES;
    localparam int META_IDX = CFG_BYTES + CK_BYTES;

    logic [7:0]       mem [TOTAL_BYTES];
    logic [31:0]      off_cfg, off_ck, off_meta;
    logic             hit;
    logic [IDX_W-1:0] widx;

    // Window decode of the write address
    always_comb begin
        off_cfg  = wr_addr - CFG_BASE;
        off_ck   = wr_addr - CK_BASE;
        off_meta = wr_addr - META_BASE;
        hit      = 1'b1;
        widx     = '0;
        if (off_cfg < 32'(CFG_BYTES))        widx = IDX_W'(off_cfg);
        else if (off_ck < 32'(CK_BYTES))     widx = IDX_W'(CK_IDX) + IDX_W'(off_ck);
        else if (off_meta < 32'(META_BYTES)) widx = IDX_W'(META_IDX) + IDX_W'(off_meta);
        else                                 hit = 1'b0;
    end

    // Byte storage, preset to the erased value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL_BYTES; i++) mem[i] <= 8'hFF;
        end else if (wr_en && hit) begin
            mem[widx] <= wr_data;
        end
    end

    // Read port, out-of-range indices return the erased value
    always_comb begin
        rd_data = 8'hFF;
        if (32'(rd_addr) < 32'(TOTAL_BYTES)) rd_data = mem[rd_addr];
    end

    // Arithmetic sum over the configuration window
    always_comb begin
        img_sum = '0;
        for (int i = 0; i < CFG_BYTES; i++) img_sum = img_sum + SUM_W'(mem[i]);
    end

    assign stored_sum = {mem[CK_IDX], mem[CK_IDX+1]};
    assign version    = {mem[META_IDX], mem[META_IDX+1]};
endmodule

// File: rtl/hex_image_decoder.sv
// Top level: character classifier, record parser and section store, plus
// the end-of-file result registers (done pulse and image consistency).
// Assumes characters arrive no faster than one per clock; always ready.
module hex_image_decoder
    import hexdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    output logic        in_ready,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        done,
    output logic        image_ok,
    output logic [2:0]  err_code
);
    logic        ch_hex, ch_colon, ch_eol;
    logic [3:0]  ch_nib;
    logic        wr_en, eof_pulse, err_raise;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    err_e        perr;
    logic [15:0] img_sum, stored_sum, version;
    logic        ok_eval;
    logic        done_q, ok_q;

    hexdec_char u_char (
        .ch(in_char), .is_hex(ch_hex), .nib(ch_nib),
        .is_colon(ch_colon), .is_eol(ch_eol)
    );

    hexdec_parser u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch_hex(ch_hex), .ch_nib(ch_nib), .ch_colon(ch_colon), .ch_eol(ch_eol),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eof_pulse(eof_pulse), .err_raise(err_raise), .err_code(perr)
    );

    hexdec_store #(.SUM_W(16)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr[IDX_W-1:0]), .rd_data(rd_data),
        .img_sum(img_sum), .stored_sum(stored_sum), .version(version)
    );

    assign ok_eval = (img_sum == stored_sum) && (version == VERSION_OK) &&
                     (perr == ERR_NONE) && !err_raise;

    // Result registers: one-cycle done, image flag held until an error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= eof_pulse;
            if (eof_pulse)      ok_q <= ok_eval;
            else if (err_raise) ok_q <= 1'b0;
        end
    end

    assign in_ready = 1'b1;
    assign done     = done_q;
    assign image_ok = ok_q;
    assign err_code = perr;
endmodule

// File: rtl/hexdec_checks.sv
// Property checker for the hex image decoder, attached by bind.
module hexdec_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       image_ok,
    input logic [2:0] err_code
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |=> (err_code == $past(err_code)));

    assert_err_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_code <= 3'd5);

    assert_ok_rises_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(image_ok) |-> done);

    assert_ok_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        image_ok |-> (err_code == 3'd0));
endmodule

bind hex_image_decoder hexdec_checks u_checks (
    .clk(clk), .rst_n(rst_n), .done(done), .image_ok(image_ok), .err_code(err_code)
);

// File: tb/test_hex_image_decoder.sv
module test_hex_image_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic       in_ready;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;
    logic       done, image_ok;
    logic [2:0] err_code;

    int tests = 0;
    int fails = 0;
    logic [7:0] rbuf [0:15];
    logic       lower = 1'b0;

    always #5 clk = ~clk;

    hex_image_decoder i_hex_image_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .image_ok(image_ok), .err_code(err_code)
    );

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 7) & 8'hFF);
    endfunction

    function automatic logic [7:0] hexch(input logic [3:0] n, input logic lc);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lc ? 8'h57 : 8'h37) + 8'(n);
    endfunction

    task automatic send_char(input logic [7:0] c);
        in_valid = 1'b1;
        in_char  = c;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_char(hexch(b[7:4], lower));
        send_char(hexch(b[3:0], lower));
    endtask

    // Sends one record from rbuf; bad adds a wrong offset to its checksum
    task automatic send_record(input int n, input logic [15:0] a, input logic [7:0] t,
                               input logic bad, input logic eol);
        logic [7:0] s;
        s = 8'(n) + a[15:8] + a[7:0] + t;
        send_char(8'h3A);
        send_byte(8'(n));
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        send_byte(t);
        for (int k = 0; k < n; k++) begin
            send_byte(rbuf[k]);
            s = s + rbuf[k];
        end
        send_byte(8'(-s) + (bad ? 8'h01 : 8'h00));
        if (eol) begin
            send_char(8'h0D);
            send_char(8'h0A);
        end
    endtask

    task automatic send_ext(input logic [15:0] hi);
        rbuf[0] = hi[15:8];
        rbuf[1] = hi[7:0];
        send_record(2, 16'h0000, 8'h04, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] exp_idx(input int i, input logic [15:0] ck,
                                           input logic [15:0] ver);
        if (i < 128)  return pat(i);
        if (i == 128) return ck[15:8];
        if (i == 129) return ck[7:0];
        case (i)
            130: return ver[15:8];
            131: return ver[7:0];
            132: return 8'h37;
            133: return 8'h38;
            134: return 8'h0A;
            135: return 8'h05;
            default: return 8'h9A;
        endcase
    endfunction

    // Builds and sends a whole file, then checks done, flag and contents
    task automatic run_image(input logic [15:0] ck_adj, input logic [15:0] ver,
                             input logic exp_ok, input string tag);
        logic [15:0] sum;
        sum = 16'd0;
        for (int i = 0; i < 128; i++) sum = sum + 16'(pat(i));
        sum = sum + ck_adj;
        send_ext(16'h0000);
        for (int r = 0; r < 8; r++) begin
            lower = r[0];
            for (int k = 0; k < 16; k++) rbuf[k] = pat(r * 16 + k);
            send_record(16, 16'(r * 16), 8'h00, 1'b0, 1'b1);
        end
        for (int k = 0; k < 4; k++) rbuf[k] = 8'h11;
        send_record(4, 16'h0080, 8'h00, 1'b0, 1'b1);  // outside: R4
        send_ext(16'h9030);
        rbuf[0] = sum[15:8];
        rbuf[1] = sum[7:0];
        send_record(2, 16'h0000, 8'h00, 1'b0, 1'b1);
        rbuf[0] = 8'h11;
        send_record(1, 16'h0002, 8'h00, 1'b0, 1'b1);  // past sum window: R4
        send_ext(16'h9050);
        rbuf[0] = ver[15:8]; rbuf[1] = ver[7:0]; rbuf[2] = 8'h37; rbuf[3] = 8'h38;
        rbuf[4] = 8'h0A;     rbuf[5] = 8'h05;    rbuf[6] = 8'h9A;
        send_record(7, 16'h0000, 8'h00, 1'b0, 1'b1);
        send_ext(16'h1234);
        for (int k = 0; k < 4; k++) rbuf[k] = 8'h11;
        send_record(4, 16'h0000, 8'h00, 1'b0, 1'b1);  // far address: R4
        check(done == 1'b0, {tag, " R9 no early done"}, int'(done), 0);
        send_record(0, 16'h0000, 8'h01, 1'b0, 1'b0);
        check(done == 1'b1, {tag, " R9 done rises"}, int'(done), 1);
        check(image_ok == exp_ok, {tag, " R12 image_ok"}, int'(image_ok), int'(exp_ok));
        @(posedge clk); #1;
        check(done == 1'b0, {tag, " R9 done falls"}, int'(done), 0);
        check(image_ok == exp_ok, {tag, " R12 image_ok held"}, int'(image_ok), int'(exp_ok));
        send_char(8'h0D);
        send_char(8'h0A);
        check(err_code == 3'd0, {tag, " R8 R10 eol after end"}, int'(err_code), 0);
        for (int i = 0; i < 137; i++) begin
            rd_addr = 8'(i);
            #1;
            check(rd_data == exp_idx(i, sum, ver), {tag, " R2 R3 R4 read sweep"},
                  int'(rd_data), int'(exp_idx(i, sum, ver)));
        end
        rd_addr = 8'd0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(err_code == 3'd0, "R1 err_code", int'(err_code), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(image_ok == 1'b0, "R1 image_ok", int'(image_ok), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        for (int i = 0; i < 137; i++) begin
            rd_addr = 8'(i);
            #1;
            check(rd_data == 8'hFF, "R1 erased read", int'(rd_data), 8'hFF);
        end

        // Good image: R2 R3 R4 R9 R10 R12
        run_image(16'h0000, 16'h0101, 1'b1, "good");

        // R8: junk after end
        send_char(8'h78);
        check(err_code == 3'd4, "R8 after end", int'(err_code), 4);
        check(image_ok == 1'b0, "R12 flag drops on error", int'(image_ok), 0);

        // R12: sum mismatch and wrong version
        do_reset();
        run_image(16'h0001, 16'h0101, 1'b0, "badsum");
        do_reset();
        run_image(16'h0000, 16'h0102, 1'b0, "badver");

        // R5 then R11: checksum error is retained over a character error
        do_reset();
        rbuf[0] = 8'h5A;
        send_record(1, 16'h0000, 8'h00, 1'b1, 1'b1);
        check(err_code == 3'd2, "R5 record checksum", int'(err_code), 2);
        send_char(8'h67);
        check(err_code == 3'd2, "R11 sticky", int'(err_code), 2);

        // R6: bad digit inside a record
        do_reset();
        send_char(8'h3A);
        send_char(8'h30);
        send_char(8'h5A);
        check(err_code == 3'd1, "R6 non-hex in record", int'(err_code), 1);

        // R6: stray character between records
        do_reset();
        send_char(8'h20);
        check(err_code == 3'd1, "R6 stray between records", int'(err_code), 1);

        // R7: unknown type
        do_reset();
        send_record(0, 16'h0000, 8'h02, 1'b0, 1'b1);
        check(err_code == 3'd3, "R7 unknown type", int'(err_code), 3);

        // R13: extended record with wrong count
        do_reset();
        rbuf[0] = 8'h90;
        send_record(1, 16'h0000, 8'h04, 1'b0, 1'b1);
        check(err_code == 3'd5, "R13 ext length", int'(err_code), 5);

        // R13: end record with data
        do_reset();
        rbuf[0] = 8'h00;
        send_record(1, 16'h0000, 8'h01, 1'b0, 1'b1);
        check(err_code == 3'd5, "R13 eof length", int'(err_code), 5);
        check(done == 1'b0, "R9 no done on bad end", int'(done), 0);

        // R3: bad-checksum extended record leaves upper bits unchanged
        do_reset();
        rbuf[0] = 8'h90; rbuf[1] = 8'h30;
        send_record(2, 16'h0000, 8'h04, 1'b1, 1'b1);
        rbuf[0] = 8'h42;
        send_record(1, 16'h0005, 8'h00, 1'b0, 1'b1);
        rd_addr = 8'd5;
        #1;
        check(rd_data == 8'h42, "R3 upper kept on bad ext", int'(rd_data), 8'h42);
        rd_addr = 8'd128;
        #1;
        check(rd_data == 8'hFF, "R3 sum window untouched", int'(rd_data), 8'hFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule